// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a 32-bit virtual address to a physical address after a translation-cache miss. It walks a two-level page table that lives in a memory reached through a single request/ready port. The virtual address is cut into three fields. The top field selects an entry in a first-level directory, and that entry names the frame holding a second-level table. The middle field selects the final entry in that table, and the low field is the byte offset inside a 4 KB page.

The walker reads the final entry and checks its valid flag and its two-bit permission field against the requested access kind. If the access is allowed, it marks the page as used, and as dirty on a store. It writes the entry back only when one of those flags actually changes, and that write finishes before the answer is returned. The answer carries a status code, the physical address and the final entry as it now stands in memory.

One walk runs at a time. The caller watches `busy` and takes the one-cycle `rsp_valid` pulse. Memory returns read data in the same cycle in which it raises `mem_ready`.

Top module: `pt_walker`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `busy`, `rsp_valid` and `mem_req` are all 0.
- R2: The fields of a virtual address are: directory index in bits 31:20, table index in bits 19:12, offset in bits 11:0. The first memory access of a walk is a read at byte address `tbl_root + 4*index[31:20]`.
- R3: An entry holds these fields: bit 24 valid, bit 23 used, bit 22 dirty, bits 21:20 permission, bits 19:0 frame number. Bits 31:25 are reserved. If the directory entry is valid, the second access is a read at `(frame << 12) + 4*index[19:12]`.
- R4: A directory entry with bit 24 clear ends the walk with status 01 (page fault) after exactly one memory read and no write.
- R5: A final entry with bit 24 clear ends the walk with status 01 and no write. Every faulting response reports a physical address of 0.
- R6: Access kinds are coded 00 load, 01 store, 10 fetch. Permission codes are 00 none, 01 load only, 10 load and store, 11 fetch only. Any other pairing, including access code 11, ends the walk with status 10 (protection fault) and no write.
- R7: An allowed access ends the walk with status 00. The physical address is `{frame, offset}`, and `rsp_pte` is the entry after any flag update.
- R8: On an allowed access the used flag is set, and on a store the dirty flag is also set. The entry is written back to the address it was read from only if its value changed. That write completes before `rsp_valid` rises.
- R9: A request is taken when `req_valid` is high and `busy` is low. `busy` stays high from the next cycle until the response. `rsp_valid` is a single-cycle pulse. Request inputs that change during a walk have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_root | input | 32 | Byte address of the directory, sampled when a request is taken |
| req_valid | input | 1 | Request strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| req_acc | input | 2 | Access kind (00 load, 01 store, 10 fetch) |
| busy | output | 1 | Walk in progress |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_status | output | 2 | 00 ok, 01 page fault, 10 protection fault |
| rsp_paddr | output | 32 | Physical address, 0 on fault |
| rsp_pte | output | 32 | Last entry read, after any flag update |
| mem_req | output | 1 | Memory access request, held until ready |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory completes the access this cycle |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ready` |

## Verification
The main sweep crosses all four permission codes, all three access kinds, all four starting combinations of the used and dirty flags, and both values of the final valid flag. This separates a wrong permission decode from a wrong flag update, and it separates a needless write-back from a missing one. Each case uses a different directory index, table index and offset, so swapped or shifted address fields show up as wrong read addresses. Memory latency varies from zero to two wait cycles to expose handshake slips. Extra cases cover invalid directory entries, which must stop after one read, a known address pair, and request inputs changed mid-walk, which must not affect the walk.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  localparam logic [1:0] ACC_LOAD  = 2'b00;
  localparam logic [1:0] ACC_STORE = 2'b01;
  localparam logic [1:0] ACC_FETCH = 2'b10;

  localparam logic [1:0] PERM_NONE  = 2'b00;
  localparam logic [1:0] PERM_RO    = 2'b01;
  localparam logic [1:0] PERM_RW    = 2'b10;
  localparam logic [1:0] PERM_XO    = 2'b11;

  localparam logic [1:0] ST_OK      = 2'b00;
  localparam logic [1:0] ST_PAGE    = 2'b01;
  localparam logic [1:0] ST_PROT    = 2'b10;

  typedef enum logic [1:0] {W_IDLE, W_DIR, W_LEAF, W_WB} walk_state_e;

endpackage

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
  parameter int VA_W  = 32,
  parameter int DIR_W = 12,
  parameter int TBL_W = 8,
  parameter int OFF_W = 12,
  parameter int PFN_W = 20,
  parameter int AW    = 32
) (
  input  logic [VA_W-1:0]  vaddr,
  input  logic [AW-1:0]    root,
  input  logic [PFN_W-1:0] dir_pfn,
  output logic [AW-1:0]    dir_addr,
  output logic [AW-1:0]    leaf_addr,
  output logic [OFF_W-1:0] offset
);
  localparam int ENT_SH = 2;

  logic [DIR_W-1:0] dir_idx;
  logic [TBL_W-1:0] tbl_idx;

  assign dir_idx = vaddr[VA_W-1 -: DIR_W];
  assign tbl_idx = vaddr[OFF_W +: TBL_W];
  assign offset  = vaddr[OFF_W-1:0];

  assign dir_addr  = root + AW'({dir_idx, {ENT_SH{1'b0}}});
  assign leaf_addr = AW'({dir_pfn, {OFF_W{1'b0}}}) + AW'({tbl_idx, {ENT_SH{1'b0}}});

endmodule

// File: rtl/pte_eval.sv
module pte_eval
  import pt_walker_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PFN_W  = 20
) (
  input  logic [DATA_W-1:0] pte,
  input  logic [1:0]        acc,
  output logic              present,
  output logic              allowed,
  output logic [DATA_W-1:0] pte_new,
  output logic              changed
);
  localparam int B_VAL  = PFN_W + 4;
  localparam int B_USED = PFN_W + 3;
  localparam int B_DIRT = PFN_W + 2;

  logic [1:0] perm;

  assign perm    = pte[PFN_W +: 2];
  assign present = pte[B_VAL];

  always_comb begin
    case (acc)
      ACC_LOAD:  allowed = (perm == PERM_RO) || (perm == PERM_RW);
      ACC_STORE: allowed = (perm == PERM_RW);
      ACC_FETCH: allowed = (perm == PERM_XO);
      default:   allowed = 1'b0;
    endcase
  end

  always_comb begin
    pte_new         = pte;
    pte_new[B_USED] = 1'b1;
    if (acc == ACC_STORE) pte_new[B_DIRT] = 1'b1;
  end

  assign changed = (pte_new != pte);

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int DIR_W  = 12,
  parameter int TBL_W  = 8,
  parameter int OFF_W  = 12,
  parameter int PFN_W  = 20,
  parameter int AW     = 32,
  parameter int DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [AW-1:0]          tbl_root,
  input  logic                   req_valid,
  input  logic [VA_W-1:0]        req_vaddr,
  input  logic [1:0]             req_acc,
  output logic                   busy,
  output logic                   rsp_valid,
  output logic [1:0]             rsp_status,
  output logic [PFN_W+OFF_W-1:0] rsp_paddr,
  output logic [DATA_W-1:0]      rsp_pte,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic [AW-1:0]          mem_addr,
  output logic [DATA_W-1:0]      mem_wdata,
  input  logic                   mem_ready,
  input  logic [DATA_W-1:0]      mem_rdata
);
  localparam int PA_W  = PFN_W + OFF_W;
  localparam int B_VAL = PFN_W + 4;

  walk_state_e       state;
  logic [VA_W-1:0]   va_q;
  logic [AW-1:0]     root_q;
  logic [1:0]        acc_q;
  logic [DATA_W-1:0] wb_q;

  logic [VA_W-1:0]   va_sel;
  logic [AW-1:0]     root_sel;
  logic [AW-1:0]     dir_addr;
  logic [AW-1:0]     leaf_addr;
  logic [OFF_W-1:0]  offset;

  logic              leaf_present;
  logic              leaf_allowed;
  logic [DATA_W-1:0] leaf_new;
  logic              leaf_changed;

  assign va_sel   = (state == W_IDLE) ? req_vaddr : va_q;
  assign root_sel = (state == W_IDLE) ? tbl_root  : root_q;

  pt_addr_gen #(
    .VA_W(VA_W), .DIR_W(DIR_W), .TBL_W(TBL_W),
    .OFF_W(OFF_W), .PFN_W(PFN_W), .AW(AW)
  ) u_addr (
    .vaddr     (va_sel),
    .root      (root_sel),
    .dir_pfn   (mem_rdata[PFN_W-1:0]),
    .dir_addr  (dir_addr),
    .leaf_addr (leaf_addr),
    .offset    (offset)
  );

  pte_eval #(.DATA_W(DATA_W), .PFN_W(PFN_W)) u_eval (
    .pte     (mem_rdata),
    .acc     (acc_q),
    .present (leaf_present),
    .allowed (leaf_allowed),
    .pte_new (leaf_new),
    .changed (leaf_changed)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= W_IDLE;
      va_q       <= '0;
      root_q     <= '0;
      acc_q      <= '0;
      wb_q       <= '0;
      busy       <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_status <= ST_OK;
      rsp_paddr  <= '0;
      rsp_pte    <= '0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        W_IDLE: begin
          if (req_valid) begin
            va_q     <= req_vaddr;
            root_q   <= tbl_root;
            acc_q    <= req_acc;
            busy     <= 1'b1;
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= dir_addr;
            state    <= W_DIR;
          end
        end
        W_DIR: begin
          if (mem_ready) begin
            if (!mem_rdata[B_VAL]) begin
              mem_req    <= 1'b0;
              busy       <= 1'b0;
              rsp_valid  <= 1'b1;
              rsp_status <= ST_PAGE;
              rsp_paddr  <= '0;
              rsp_pte    <= mem_rdata;
              state      <= W_IDLE;
            end else begin
              mem_addr <= leaf_addr;
              state    <= W_LEAF;
            end
          end
        end
        W_LEAF: begin
          if (mem_ready) begin
            if (!leaf_present || !leaf_allowed) begin
              mem_req    <= 1'b0;
              busy       <= 1'b0;
              rsp_valid  <= 1'b1;
              rsp_status <= leaf_present ? ST_PROT : ST_PAGE;
              rsp_paddr  <= '0;
              rsp_pte    <= mem_rdata;
              state      <= W_IDLE;
            end else if (leaf_changed) begin
              mem_we    <= 1'b1;
              mem_wdata <= leaf_new;
              wb_q      <= leaf_new;
              state     <= W_WB;
            end else begin
              mem_req    <= 1'b0;
              busy       <= 1'b0;
              rsp_valid  <= 1'b1;
              rsp_status <= ST_OK;
              rsp_paddr  <= PA_W'({mem_rdata[PFN_W-1:0], offset});
              rsp_pte    <= mem_rdata;
              state      <= W_IDLE;
            end
          end
        end
        W_WB: begin
          if (mem_ready) begin
            mem_req    <= 1'b0;
            mem_we     <= 1'b0;
            busy       <= 1'b0;
            rsp_valid  <= 1'b1;
            rsp_status <= ST_OK;
            rsp_paddr  <= PA_W'({wb_q[PFN_W-1:0], offset});
            rsp_pte    <= wb_q;
            state      <= W_IDLE;
          end
        end
        default: state <= W_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int AW     = 32,
  parameter int DATA_W = 32,
  parameter int PA_W   = 32,
  parameter int PFN_W  = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              rsp_valid,
  input logic [1:0]        rsp_status,
  input logic [PA_W-1:0]   rsp_paddr,
  input logic              mem_req,
  input logic              mem_we,
  input logic [AW-1:0]     mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ready
);
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R9

  AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req); // R9

  AST_MEM_HELD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R2

  AST_WB_MARKS_USED: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> mem_wdata[PFN_W+3]); // R8

  AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status != 2'b00) |-> (rsp_paddr == '0)); // R5

  AST_STATUS_CODE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_status != 2'b11)); // R6

endmodule

bind pt_walker pt_walker_chk #(
  .AW(AW), .DATA_W(DATA_W), .PA_W(PFN_W+OFF_W), .PFN_W(PFN_W)
) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .rsp_valid(rsp_valid),
  .rsp_status(rsp_status), .rsp_paddr(rsp_paddr), .mem_req(mem_req),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_ready(mem_ready)
);

// File: tb/test_pt_walker.sv
module test_pt_walker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] tbl_root = 32'h0010_0000;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_acc = '0;
  logic        busy, rsp_valid, mem_req, mem_we;
  logic [1:0]  rsp_status;
  logic [31:0] rsp_paddr, rsp_pte, mem_addr, mem_wdata;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_rdata = '0;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pt_walker i_pt_walker (
    .clk(clk), .rst(rst), .tbl_root(tbl_root), .req_valid(req_valid),
    .req_vaddr(req_vaddr), .req_acc(req_acc), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_paddr(rsp_paddr),
    .rsp_pte(rsp_pte), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata)
  );

  // Memory model: word store, latency in wait cycles, access log
  logic [31:0] mem [int unsigned];
  int          lat = 0;
  int          wcnt = 0;
  int          rd_cnt = 0;
  int          wr_cnt = 0;
  logic [31:0] rd_log [0:3];
  logic [31:0] wr_addr;

  always @(negedge clk) begin
    if (mem_ready) begin
      mem_ready = 1'b0;
    end else if (mem_req) begin
      if (wcnt >= lat) begin
        wcnt = 0;
        mem_ready = 1'b1;
        if (mem_we) begin
          mem[mem_addr >> 2] = mem_wdata;
          wr_addr = mem_addr;
          wr_cnt++;
        end else begin
          mem_rdata = mem.exists(mem_addr >> 2) ? mem[mem_addr >> 2] : 32'h0;
          if (rd_cnt < 4) rd_log[rd_cnt] = mem_addr;
          rd_cnt++;
        end
      end else begin
        wcnt++;
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_pte(input bit v, input bit u, input bit d,
                                         input logic [1:0] p, input logic [19:0] f);
    return {7'h00, v, u, d, p, f};
  endfunction

  // Issues one walk, changes the request inputs mid-walk, waits for the response
  task automatic walk(input logic [31:0] va, input logic [1:0] acc);
    int n;
    rd_cnt = 0; wr_cnt = 0; wcnt = 0; wr_addr = '0;
    req_vaddr = va; req_acc = acc; req_valid = 1'b1;
    @(negedge clk);
    chk("R9 busy after accept", busy, 1);
    req_vaddr = ~va; req_acc = acc ^ 2'b01;
    n = 0;
    while (!rsp_valid && n < 60) begin
      @(negedge clk);
      n++;
    end
    req_valid = 1'b0;
    chk("R9 response arrives", rsp_valid, 1);
    chk("R9 busy low at response", busy, 0);
    @(negedge clk);
    chk("R9 rsp_valid single pulse", rsp_valid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", busy, 0);
    chk("R1 rsp_valid in reset", rsp_valid, 0);
    chk("R1 mem_req in reset", mem_req, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy after reset", busy, 0);
    chk("R1 mem_req after reset", mem_req, 0);

    // Main sweep: permission x access x flags x leaf valid
    for (int c = 0; c < 96; c++) begin
      logic [1:0]  p;
      logic [1:0]  a;
      logic [1:0]  fl;
      bit          v;
      bit          ok;
      logic [11:0] di;
      logic [7:0]  ti;
      logic [11:0] off;
      logic [19:0] dpfn;
      logic [19:0] lpfn;
      logic [31:0] va;
      logic [31:0] dad;
      logic [31:0] lad;
      logic [31:0] ent;
      logic [31:0] nent;
      p  = 2'(c % 4);
      a  = 2'((c / 4) % 3);
      fl = 2'((c / 12) % 4);
      v  = ((c / 48) % 2) == 0;
      di = 12'((c * 37 + 5) % 4096);
      ti = 8'((c * 11 + 3) % 256);
      off = 12'((c * 131 + 7) % 4096);
      dpfn = 20'h00300 + 20'(c);
      lpfn = 20'h0A000 + 20'(c * 7);
      va  = {di, ti, off};
      dad = tbl_root + {18'h0, di, 2'b00};
      lad = {dpfn, 12'h000} + {22'h0, ti, 2'b00};
      ent = mk_pte(v, fl[1], fl[0], p, lpfn);
      mem.delete();
      mem[dad >> 2] = mk_pte(1'b1, 1'b0, 1'b0, 2'b00, dpfn) | 32'hFE00_0000;
      mem[lad >> 2] = ent;
      lat = c % 3;
      ok = (a == 2'b00 && (p == 2'b01 || p == 2'b10)) ||
           (a == 2'b01 && p == 2'b10) || (a == 2'b10 && p == 2'b11);
      nent = ent | 32'h0080_0000 | ((a == 2'b01) ? 32'h0040_0000 : 32'h0);
      walk(va, a);
      chk("R2 directory read address", rd_log[0], dad);
      chk("R3 leaf read address", rd_log[1], lad);
      chk("R3 two reads", rd_cnt, 2);
      if (!v) begin
        chk("R5 invalid leaf status", rsp_status, 2'b01);
        chk("R5 invalid leaf paddr", rsp_paddr, 0);
        chk("R5 invalid leaf no write", wr_cnt, 0);
        chk("R5 entry untouched", mem[lad >> 2], ent);
      end else if (!ok) begin
        chk("R6 protection status", rsp_status, 2'b10);
        chk("R5 protection paddr", rsp_paddr, 0);
        chk("R6 protection no write", wr_cnt, 0);
        chk("R6 entry untouched", mem[lad >> 2], ent);
      end else begin
        chk("R7 ok status", rsp_status, 2'b00);
        chk("R7 physical address", rsp_paddr, {lpfn, off});
        chk("R7 reported entry", rsp_pte, nent);
        chk("R8 write only on change", wr_cnt, (nent != ent) ? 1 : 0);
        if (nent != ent) chk("R8 write address", wr_addr, lad);
        chk("R8 memory entry", mem[lad >> 2], nent);
      end
    end

    // Directory entry invalid: stop after one read
    for (int k = 0; k < 4; k++) begin
      logic [31:0] va;
      logic [31:0] dad;
      va  = {12'(k * 1000 + 1), 8'(k * 50), 12'(k * 9)};
      dad = tbl_root + {18'h0, va[31:20], 2'b00};
      mem.delete();
      mem[dad >> 2] = mk_pte(1'b0, 1'b1, 1'b1, 2'(k), 20'h00400);
      lat = k % 3;
      walk(va, 2'(k % 3));
      chk("R4 directory fault status", rsp_status, 2'b01);
      chk("R4 single read", rd_cnt, 1);
      chk("R4 no write", wr_cnt, 0);
      chk("R4 read address", rd_log[0], dad);
      chk("R5 directory fault paddr", rsp_paddr, 0);
    end

    // Access code 11 is never allowed
    mem.delete();
    mem[(tbl_root + 32'h4) >> 2] = mk_pte(1'b1, 1'b0, 1'b0, 2'b00, 20'h00500);
    mem[32'h0050_0000 >> 2] = mk_pte(1'b1, 1'b0, 1'b0, 2'b11, 20'h00777);
    lat = 1;
    walk(32'h0010_0ABC, 2'b11);
    chk("R6 access 11 faults", rsp_status, 2'b10);
    chk("R6 access 11 no write", wr_cnt, 0);

    // Known pair: 0x12345678 to frame 0x01000
    mem.delete();
    mem[(tbl_root + 32'h48C) >> 2] = mk_pte(1'b1, 1'b0, 1'b0, 2'b00, 20'h00800);
    mem[(32'h0080_0000 + 32'h114) >> 2] = mk_pte(1'b1, 1'b0, 1'b0, 2'b01, 20'h01000);
    lat = 0;
    walk(32'h1234_5678, 2'b00);
    chk("R7 known pair status", rsp_status, 2'b00);
    chk("R7 known pair paddr", rsp_paddr, 32'h0100_0678);
    chk("R8 known pair used flag written", wr_cnt, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule